// File: doc/BRIEF.md
# Dual Integer / Floating-Point Register File

This block holds the two architectural register files of a 64-bit load/store processor: one for integer values and one for floating-point values. Each file has 32 entries of 64 bits and, in every cycle, serves two source operand reads and takes one destination write. The highest-numbered entry of each file is a constant zero: it always reads as zero, and writes to it are thrown away.

The second integer operand can come from a small instruction literal instead of a register. When the literal is selected, it is zero-extended to the full width. A transfer request copies one raw 64-bit value from a register in one file into a register in the other file. The bits are not changed or interpreted in any way.

Writes take effect on the rising clock edge, and reset is synchronous. An operand read of the register being written in the same cycle returns the new data. A transfer reads the value its source register held before the edge.

Top module: `dual_regfile`

## Requirements
- R1: While `rst` is high at a rising edge, every register of both files is cleared to zero. After reset, every operand port reads zero until a register is written.
- R2: A write with `int_we` = 1 (or `fp_we` = 1) stores `*_wd` into entry `*_wa` at the rising edge. The value can be read on both operand ports of that file from the next cycle on, and the other file does not change.
- R3: Integer entry 31 reads as zero on every integer operand port, and writes to it are discarded.
- R4: Floating-point entry 31 reads as zero on every floating-point operand port, and writes to it are discarded.
- R5: An operand read whose address matches an active write in the same cycle returns the write data, on both ports of the written file. This does not apply to entry 31, which stays zero.
- R6: With `int_lit_sel` = 1, `int_rb_data` equals `{56'b0, int_lit}`. With `int_lit_sel` = 0, it is the register selected by `int_rb_addr`. The select has no effect on `int_ra_data`.
- R7: With `xfer_req` = 1, the rising edge copies a register from one file into the other, bit for bit. With `xfer_dir` = 0, integer entry `xfer_src` is copied into floating-point entry `xfer_dst`. With `xfer_dir` = 1, floating-point entry `xfer_src` is copied into integer entry `xfer_dst`.
- R8: A transfer copies the value its source entry held before the edge, even when that entry is being written in the same cycle.
- R9: A transfer whose `xfer_dst` is 31 leaves the target file unchanged, and entry 31 still reads zero.
- R10: In a cycle with a transfer, the normal write port of the target file is ignored. The other file's normal write still happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| int_ra_addr | input | 5 | Integer operand A address |
| int_rb_addr | input | 5 | Integer operand B address |
| int_ra_data | output | 64 | Integer operand A value |
| int_rb_data | output | 64 | Integer operand B value or extended literal |
| int_lit_sel | input | 1 | 1 selects the literal for operand B |
| int_lit | input | 8 | Instruction literal |
| int_we | input | 1 | Integer write enable |
| int_wa | input | 5 | Integer write address |
| int_wd | input | 64 | Integer write data |
| fp_ra_addr | input | 5 | Floating-point operand A address |
| fp_rb_addr | input | 5 | Floating-point operand B address |
| fp_ra_data | output | 64 | Floating-point operand A value |
| fp_rb_data | output | 64 | Floating-point operand B value |
| fp_we | input | 1 | Floating-point write enable |
| fp_wa | input | 5 | Floating-point write address |
| fp_wd | input | 64 | Floating-point write data |
| xfer_req | input | 1 | Cross-file transfer request |
| xfer_dir | input | 1 | 0: integer to floating point, 1: floating point to integer |
| xfer_src | input | 5 | Transfer source entry |
| xfer_dst | input | 5 | Transfer destination entry |

## Verification
Each file is filled with a distinct per-entry pattern, so a misrouted address or a leak between the files shows as a wrong value. Operand B is read at an offset from operand A, which tells the two read ports apart. Same-cycle write and read pairs separate the bypass from a plain registered read. Writes to entry 31 show whether the zero entry is really hardwired. Literals of all-zeros, all-ones and mixed bits check the extension against sign extension. Transfers are run in both directions, to entry 31, against a normal write to the target file, and against a write to their own source entry; these cases separate the priority rule and the pre-edge source value from a naive copy.

// File: rtl/regfile_pkg.sv
package regfile_pkg;
   localparam int XLEN   = 64;
   localparam int NREGS  = 32;
   localparam int LITW   = 8;
   localparam int RAW    = $clog2(NREGS);

   typedef enum logic {
      XF_INT2FP = 1'b0,
      XF_FP2INT = 1'b1
   } xfer_dir_e;

   typedef struct packed {
      logic            en;
      logic [RAW-1:0]  addr;
      logic [XLEN-1:0] data;
   } wr_port_t;
endpackage

// File: rtl/rf_bank.sv
module rf_bank #(
   parameter int WIDTH     = 64,
   parameter int DEPTH     = 32,
   parameter int NRD       = 2,
   parameter bit ZERO_LAST = 1'b1,
   localparam int AW       = $clog2(DEPTH)
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       we,
   input  logic [AW-1:0]              wa,
   input  logic [WIDTH-1:0]           wd,
   input  logic [NRD-1:0][AW-1:0]     rd_addr,
   output logic [NRD-1:0][WIDTH-1:0]  rd_data,
   input  logic [AW-1:0]              raw_addr,
   output logic [WIDTH-1:0]           raw_data
);
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   if (DEPTH != (1 << AW)) begin : g_chk_depth
      $error("rf_bank: DEPTH must be a power of two");
   end
   if (NRD < 1) begin : g_chk_nrd
      $error("rf_bank: NRD must be at least one");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic             wr_live;

   if (ZERO_LAST) begin : g_zero_last
      assign wr_live = we && (wa != LAST);
   end else begin : g_plain
      assign wr_live = we;
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      if (ZERO_LAST && (i == DEPTH - 1)) begin : g_const
         assign mem[i] = '0;
      end else begin : g_store
         always_ff @(posedge clk) begin
            if (rst)
               mem[i] <= '0;
            else if (wr_live && (wa == AW'(i)))
               mem[i] <= wd;
         end
      end
   end

   for (genvar p = 0; p < NRD; p++) begin : g_rd
      always_comb begin
         if (wr_live && (wa == rd_addr[p]))
            rd_data[p] = wd;
         else
            rd_data[p] = mem[rd_addr[p]];
      end
   end

   assign raw_data = mem[raw_addr];
endmodule

// File: rtl/opnd_sel.sv
module opnd_sel #(
   parameter int WIDTH = 64,
   parameter int LITW  = 8
) (
   input  logic [WIDTH-1:0] reg_val,
   input  logic             lit_sel,
   input  logic [LITW-1:0]  lit,
   output logic [WIDTH-1:0] opnd
);
   if (LITW > WIDTH || LITW < 1) begin : g_chk_lit
      $error("opnd_sel: LITW must lie in 1..WIDTH");
   end

   logic [WIDTH-1:0] lit_ext;

   if (LITW == WIDTH) begin : g_full
      assign lit_ext = lit;
   end else begin : g_ext
      assign lit_ext = {{(WIDTH - LITW){1'b0}}, lit};
   end

   assign opnd = lit_sel ? lit_ext : reg_val;
endmodule

// File: rtl/xfer_route.sv
module xfer_route
   import regfile_pkg::*;
#(
   parameter int WIDTH = 64,
   parameter int AW    = 5
) (
   input  logic             req,
   input  logic             dir,
   input  logic [AW-1:0]    dst,
   input  logic [WIDTH-1:0] int_src_val,
   input  logic [WIDTH-1:0] fp_src_val,
   input  logic             int_we_in,
   input  logic [AW-1:0]    int_wa_in,
   input  logic [WIDTH-1:0] int_wd_in,
   input  logic             fp_we_in,
   input  logic [AW-1:0]    fp_wa_in,
   input  logic [WIDTH-1:0] fp_wd_in,
   output logic             int_we_out,
   output logic [AW-1:0]    int_wa_out,
   output logic [WIDTH-1:0] int_wd_out,
   output logic             fp_we_out,
   output logic [AW-1:0]    fp_wa_out,
   output logic [WIDTH-1:0] fp_wd_out
);
   logic to_fp, to_int;

   assign to_fp  = req && (xfer_dir_e'(dir) == XF_INT2FP);
   assign to_int = req && (xfer_dir_e'(dir) == XF_FP2INT);

   always_comb begin
      if (to_int) begin
         int_we_out = 1'b1;
         int_wa_out = dst;
         int_wd_out = fp_src_val;
      end else begin
         int_we_out = int_we_in;
         int_wa_out = int_wa_in;
         int_wd_out = int_wd_in;
      end
   end

   always_comb begin
      if (to_fp) begin
         fp_we_out = 1'b1;
         fp_wa_out = dst;
         fp_wd_out = int_src_val;
      end else begin
         fp_we_out = fp_we_in;
         fp_wa_out = fp_wa_in;
         fp_wd_out = fp_wd_in;
      end
   end
endmodule

// File: rtl/dual_regfile.sv
module dual_regfile
   import regfile_pkg::*;
#(
   parameter int WIDTH = XLEN,
   parameter int DEPTH = NREGS,
   parameter int LW    = LITW,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [AW-1:0]    int_ra_addr,
   input  logic [AW-1:0]    int_rb_addr,
   output logic [WIDTH-1:0] int_ra_data,
   output logic [WIDTH-1:0] int_rb_data,
   input  logic             int_lit_sel,
   input  logic [LW-1:0]    int_lit,
   input  logic             int_we,
   input  logic [AW-1:0]    int_wa,
   input  logic [WIDTH-1:0] int_wd,
   input  logic [AW-1:0]    fp_ra_addr,
   input  logic [AW-1:0]    fp_rb_addr,
   output logic [WIDTH-1:0] fp_ra_data,
   output logic [WIDTH-1:0] fp_rb_data,
   input  logic             fp_we,
   input  logic [AW-1:0]    fp_wa,
   input  logic [WIDTH-1:0] fp_wd,
   input  logic             xfer_req,
   input  logic             xfer_dir,
   input  logic [AW-1:0]    xfer_src,
   input  logic [AW-1:0]    xfer_dst
);
   logic                     iw_en, fw_en;
   logic [AW-1:0]            iw_addr, fw_addr;
   logic [WIDTH-1:0]         iw_data, fw_data;
   logic [WIDTH-1:0]         int_raw, fp_raw;
   logic [1:0][WIDTH-1:0]    int_rd, fp_rd;

   xfer_route #(.WIDTH(WIDTH), .AW(AW)) u_route (
      .req         (xfer_req),
      .dir         (xfer_dir),
      .dst         (xfer_dst),
      .int_src_val (int_raw),
      .fp_src_val  (fp_raw),
      .int_we_in   (int_we),
      .int_wa_in   (int_wa),
      .int_wd_in   (int_wd),
      .fp_we_in    (fp_we),
      .fp_wa_in    (fp_wa),
      .fp_wd_in    (fp_wd),
      .int_we_out  (iw_en),
      .int_wa_out  (iw_addr),
      .int_wd_out  (iw_data),
      .fp_we_out   (fw_en),
      .fp_wa_out   (fw_addr),
      .fp_wd_out   (fw_data)
   );

   rf_bank #(.WIDTH(WIDTH), .DEPTH(DEPTH), .NRD(2), .ZERO_LAST(1'b1)) u_int (
      .clk      (clk),
      .rst      (rst),
      .we       (iw_en),
      .wa       (iw_addr),
      .wd       (iw_data),
      .rd_addr  ({int_rb_addr, int_ra_addr}),
      .rd_data  (int_rd),
      .raw_addr (xfer_src),
      .raw_data (int_raw)
   );

   rf_bank #(.WIDTH(WIDTH), .DEPTH(DEPTH), .NRD(2), .ZERO_LAST(1'b1)) u_fp (
      .clk      (clk),
      .rst      (rst),
      .we       (fw_en),
      .wa       (fw_addr),
      .wd       (fw_data),
      .rd_addr  ({fp_rb_addr, fp_ra_addr}),
      .rd_data  (fp_rd),
      .raw_addr (xfer_src),
      .raw_data (fp_raw)
   );

   opnd_sel #(.WIDTH(WIDTH), .LITW(LW)) u_bsel (
      .reg_val (int_rd[1]),
      .lit_sel (int_lit_sel),
      .lit     (int_lit),
      .opnd    (int_rb_data)
   );

   assign int_ra_data = int_rd[0];
   assign fp_ra_data  = fp_rd[0];
   assign fp_rb_data  = fp_rd[1];
endmodule

// File: rtl/rf_checker.sv
module rf_checker #(
   parameter int WIDTH = 64,
   parameter int DEPTH = 32,
   parameter int LW    = 8,
   localparam int AW   = $clog2(DEPTH)
) (
   input logic             clk,
   input logic             rst,
   input logic [AW-1:0]    int_ra_addr,
   input logic [AW-1:0]    int_rb_addr,
   input logic [WIDTH-1:0] int_ra_data,
   input logic [WIDTH-1:0] int_rb_data,
   input logic             int_lit_sel,
   input logic [LW-1:0]    int_lit,
   input logic             int_we,
   input logic [AW-1:0]    int_wa,
   input logic [WIDTH-1:0] int_wd,
   input logic [AW-1:0]    fp_ra_addr,
   input logic [AW-1:0]    fp_rb_addr,
   input logic [WIDTH-1:0] fp_ra_data,
   input logic [WIDTH-1:0] fp_rb_data,
   input logic             fp_we,
   input logic [AW-1:0]    fp_wa,
   input logic [WIDTH-1:0] fp_wd,
   input logic             xfer_req,
   input logic             xfer_dir,
   input logic [AW-1:0]    xfer_src,
   input logic [AW-1:0]    xfer_dst
);
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   a_r1_reset_zero: assert property (@(posedge clk) disable iff (rst)
      ($past(rst) && !int_we && !xfer_req) |-> (int_ra_data == '0));

   a_r3_int_zero: assert property (@(posedge clk) disable iff (rst)
      (int_ra_addr == LAST) |-> (int_ra_data == '0));

   a_r4_fp_zero: assert property (@(posedge clk) disable iff (rst)
      (fp_rb_addr == LAST) |-> (fp_rb_data == '0));

   a_r5_bypass: assert property (@(posedge clk) disable iff (rst)
      (fp_we && !xfer_req && fp_wa != LAST && fp_ra_addr == fp_wa)
         |-> (fp_ra_data == fp_wd));

   a_r6_literal: assert property (@(posedge clk) disable iff (rst)
      int_lit_sel |-> (int_rb_data == {{(WIDTH - LW){1'b0}}, int_lit}));

   a_r7_move_bits: assert property (@(posedge clk) disable iff (rst)
      (xfer_req && !xfer_dir && xfer_dst != LAST && int_ra_addr == xfer_src
       && fp_ra_addr == xfer_dst && !(int_we && int_wa == xfer_src))
         |-> (fp_ra_data == int_ra_data));
endmodule

bind dual_regfile rf_checker #(.WIDTH(WIDTH), .DEPTH(DEPTH), .LW(LW)) u_chk (.*);

// File: tb/dual_regfile_bench.sv
module dual_regfile_bench;
   logic        clk = 1'b0;
   logic        rst;
   logic [4:0]  int_ra_addr, int_rb_addr, fp_ra_addr, fp_rb_addr;
   logic [63:0] int_ra_data, int_rb_data, fp_ra_data, fp_rb_data;
   logic        int_lit_sel;
   logic [7:0]  int_lit;
   logic        int_we, fp_we;
   logic [4:0]  int_wa, fp_wa;
   logic [63:0] int_wd, fp_wd;
   logic        xfer_req, xfer_dir;
   logic [4:0]  xfer_src, xfer_dst;

   logic [63:0] im [32];
   logic [63:0] fm [32];
   int          n_chk = 0;
   int          n_bad = 0;
   bit          done  = 1'b0;

   always #5 clk = ~clk;

   dual_regfile u_dual_regfile (.*);

   function automatic logic [63:0] ipat(input int a);
      return {32'hC3A5_0000 | 32'(a), ~(32'h0101_0101 * 32'(a + 1))};
   endfunction

   function automatic logic [63:0] fpat(input int a);
      return {~(32'h0F0F_1000 + 32'(a)), 32'h3C00_0000 ^ (32'(a) << 8)};
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic idle();
      int_we = 0; fp_we = 0; xfer_req = 0; xfer_dir = 0; int_lit_sel = 0;
      int_lit = 0; int_wa = 0; fp_wa = 0; int_wd = 0; fp_wd = 0;
      xfer_src = 0; xfer_dst = 0;
   endtask

   task automatic t_reset();
      for (int a = 0; a < 32; a++) begin
         @(negedge clk);
         int_ra_addr = 5'(a); int_rb_addr = 5'(31 - a);
         fp_ra_addr = 5'(a); fp_rb_addr = 5'(31 - a);
         #1;
         chk("R1 int A", int_ra_data, 64'd0);
         chk("R1 int B", int_rb_data, 64'd0);
         chk("R1 fp A", fp_ra_data, 64'd0);
         chk("R1 fp B", fp_rb_data, 64'd0);
      end
   endtask

   task automatic t_fill();
      for (int a = 0; a < 32; a++) begin
         @(negedge clk);
         int_we = 1; int_wa = 5'(a); int_wd = ipat(a);
         fp_we = 1; fp_wa = 5'(a); fp_wd = fpat(a);
         if (a != 31) begin
            im[a] = ipat(a);
            fm[a] = fpat(a);
         end
      end
      @(negedge clk);
      idle();
      for (int a = 0; a < 32; a++) begin
         @(negedge clk);
         int_ra_addr = 5'(a); int_rb_addr = 5'((a + 5) % 32);
         fp_ra_addr = 5'(a); fp_rb_addr = 5'((a + 9) % 32);
         #1;
         chk(a == 31 ? "R3 int A" : "R2 int A", int_ra_data, im[a]);
         chk("R2 int B", int_rb_data, im[(a + 5) % 32]);
         chk(a == 31 ? "R4 fp A" : "R2 fp A", fp_ra_data, fm[a]);
         chk("R2 fp B", fp_rb_data, fm[(a + 9) % 32]);
      end
   endtask

   task automatic t_zero31();
      @(negedge clk);
      int_we = 1; int_wa = 31; int_wd = '1;
      fp_we = 1; fp_wa = 31; fp_wd = '1;
      int_ra_addr = 31; int_rb_addr = 31; fp_ra_addr = 31; fp_rb_addr = 31;
      #1;
      chk("R3 int31 same cycle", int_ra_data, 64'd0);
      chk("R4 fp31 same cycle", fp_rb_data, 64'd0);
      @(negedge clk);
      idle();
      #1;
      chk("R3 int31 after write", int_rb_data, 64'd0);
      chk("R4 fp31 after write", fp_ra_data, 64'd0);
   endtask

   task automatic t_bypass();
      @(negedge clk);
      int_we = 1; int_wa = 7; int_wd = 64'hDEAD_BEEF_0BAD_F00D;
      fp_we = 1; fp_wa = 9; fp_wd = 64'h1234_5678_9ABC_DEF0;
      int_ra_addr = 7; int_rb_addr = 7; fp_ra_addr = 7; fp_rb_addr = 9;
      #1;
      chk("R5 int A bypass", int_ra_data, 64'hDEAD_BEEF_0BAD_F00D);
      chk("R5 int B bypass", int_rb_data, 64'hDEAD_BEEF_0BAD_F00D);
      chk("R5 fp B bypass", fp_rb_data, 64'h1234_5678_9ABC_DEF0);
      chk("R2 fp A other file unchanged", fp_ra_data, fm[7]);
      im[7] = 64'hDEAD_BEEF_0BAD_F00D;
      fm[9] = 64'h1234_5678_9ABC_DEF0;
      @(negedge clk);
      idle();
      fp_ra_addr = 9;
      #1;
      chk("R5 int stored", int_ra_data, im[7]);
      chk("R5 fp stored", fp_ra_data, fm[9]);
   endtask

   task automatic t_literal();
      logic [7:0] lits [4] = '{8'h00, 8'hFF, 8'h5A, 8'h81};
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         int_ra_addr = 3; int_rb_addr = 4; int_lit_sel = 1; int_lit = lits[k];
         #1;
         chk("R6 literal zero-extended", int_rb_data, {56'd0, lits[k]});
         chk("R6 port A unaffected", int_ra_data, im[3]);
         @(negedge clk);
         int_lit_sel = 0;
         #1;
         chk("R6 register when unselected", int_rb_data, im[4]);
      end
   endtask

   task automatic t_xfer();
      // int -> fp
      @(negedge clk);
      xfer_req = 1; xfer_dir = 0; xfer_src = 3; xfer_dst = 12;
      fm[12] = im[3];
      @(negedge clk);
      idle(); fp_ra_addr = 12;
      #1;
      chk("R7 int to fp", fp_ra_data, fm[12]);
      // fp -> int
      @(negedge clk);
      xfer_req = 1; xfer_dir = 1; xfer_src = 20; xfer_dst = 15;
      im[15] = fm[20];
      @(negedge clk);
      idle(); int_ra_addr = 15;
      #1;
      chk("R7 fp to int", int_ra_data, im[15]);
      // destination 31
      @(negedge clk);
      xfer_req = 1; xfer_dir = 0; xfer_src = 5; xfer_dst = 31;
      @(negedge clk);
      idle(); fp_ra_addr = 31; fp_rb_addr = 30;
      #1;
      chk("R9 fp31 stays zero", fp_ra_data, 64'd0);
      chk("R9 fp30 unchanged", fp_rb_data, fm[30]);
      // priority over the target file's write port
      @(negedge clk);
      xfer_req = 1; xfer_dir = 0; xfer_src = 1; xfer_dst = 10;
      fp_we = 1; fp_wa = 11; fp_wd = 64'hFFFF_0000_FFFF_0000;
      int_we = 1; int_wa = 6; int_wd = 64'h0606_0606_0606_0606;
      fm[10] = im[1];
      im[6] = 64'h0606_0606_0606_0606;
      @(negedge clk);
      idle(); fp_ra_addr = 10; fp_rb_addr = 11; int_ra_addr = 6;
      #1;
      chk("R10 transfer written", fp_ra_data, fm[10]);
      chk("R10 normal fp write ignored", fp_rb_data, fm[11]);
      chk("R10 other file write kept", int_ra_data, im[6]);
      // source value before the edge
      @(negedge clk);
      xfer_req = 1; xfer_dir = 0; xfer_src = 2; xfer_dst = 13;
      int_we = 1; int_wa = 2; int_wd = 64'hAAAA_5555_AAAA_5555;
      fm[13] = im[2];
      im[2] = 64'hAAAA_5555_AAAA_5555;
      @(negedge clk);
      idle(); fp_ra_addr = 13; int_ra_addr = 2;
      #1;
      chk("R8 old source value moved", fp_ra_data, fm[13]);
      chk("R8 source write kept", int_ra_data, im[2]);
   endtask

   initial begin
      for (int a = 0; a < 32; a++) begin
         im[a] = '0;
         fm[a] = '0;
      end
      idle();
      int_ra_addr = 0; int_rb_addr = 0; fp_ra_addr = 0; fp_rb_addr = 0;
      rst = 1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 0;
      t_reset();
      t_fill();
      t_zero31();
      t_bypass();
      t_literal();
      t_xfer();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      #200000;
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule